// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge/Level Capture

This block gathers a parameterised number of interrupt request lines (up to 32) and presents them to a processor as a single interrupt output. Each line is fixed at build time as either edge-sensitive or level-sensitive. Captured requests are held in a status word. Each line has an enable bit. Software sees the enabled requests in a pending word and clears serviced requests through an acknowledge register.

A word-addressed 32-bit register port gives access to the controller. Reads are combinational from the current state, and writes take effect on the next rising clock edge. Enable bits can be loaded as a whole word, or set and cleared per bit through two separate write-only registers, so no read-modify-write sequence is needed. A vector register returns the lowest-numbered request that is both captured and enabled, and returns all ones when there is none. A two-bit master control word gates the output. Request lines are assumed to be synchronous to the clock already.

Top module: `ivc_top`

## Requirements
- R1: Registers are selected by a 3-bit word index: 0 status (read-only), 1 pending (read-only), 2 enable, 3 acknowledge (write-only), 4 enable-set (write-only), 5 enable-clear (write-only), 6 vector (read-only), 7 master control. The write-only registers read as zero.
- R2: For a line whose bit in `EDGE_MASK` is 1, a 0-to-1 transition of the line, seen on a clock edge, sets its status bit on that edge. The status bit then stays set until it is acknowledged. A line that is already high when reset is released counts as a rising transition.
- R3: For a line whose bit in `EDGE_MASK` is 0, the status bit is set on every clock edge at which the line is high.
- R4: Writing index 3 clears each status bit whose data bit is 1. If a capture for the same line occurs on the same edge, the capture wins, so an acknowledged level line that is still high stays set.
- R5: Writing index 2 replaces all enable bits with the written word. With no write to indices 2, 4 or 5, the enable bits hold their value.
- R6: Writing index 4 sets the enable bits where the data bit is 1 and leaves the other enable bits unchanged.
- R7: Writing index 5 clears the enable bits where the data bit is 1 and leaves the other enable bits unchanged.
- R8: The pending word reads as the status word ANDed with the enable word.
- R9: The vector register reads as the lowest index with a pending bit set, zero-extended to 32 bits. It reads as 0xFFFFFFFF when no bit is pending.
- R10: Writing index 7 stores data bits [1:0], where bit 0 is the master enable and bit 1 is the output enable. Reading index 7 returns those two bits, with all other bits zero.
- R11: `irq_o` is high exactly when both master control bits are 1 and at least one pending bit is 1.
- R12: Status, pending and enable bits at positions `NUM_IN` and above always read as zero.
- R13: While the controller is in reset and after reset, every register is zero. Writes to indices 0, 1 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised internally over two clock edges |
| reg_addr | input | 3 | Register word index |
| reg_we | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational from the current state |
| irq_in | input | NUM_IN | Interrupt request lines, synchronous to `clk` |
| irq_o | output | 1 | Interrupt output to the processor |

## Verification
A write or a request transition that is applied between edges becomes visible on the rising edge that follows, so `reg_rdata` and `irq_o` show the result in the same cycle after that edge. No extra pipeline stage lies on the read path. The reference model in the bench advances its state on every rising edge from the inputs that are stable there, and the bench compares both outputs at the falling edge against the model. Reset release takes two edges through the synchroniser, and the model stays in reset for exactly those two edges before it starts to update.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_PEND  = 3'd1,
    SEL_EN    = 3'd2,
    SEL_ACK   = 3'd3,
    SEL_ENSET = 3'd4,
    SEL_ENCLR = 3'd5,
    SEL_VEC   = 3'd6,
    SEL_MSTR  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/ivc_capture.sv
module ivc_capture #(
  parameter int unsigned NUM_IN    = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] req_in,
  input  logic [NUM_IN-1:0] ack_bits,
  output logic [NUM_IN-1:0] stat_q
);
  logic [NUM_IN-1:0] hit;
  logic [NUM_IN-1:0] stat_d;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_line
    if (EDGE_MASK[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= req_in[g];
      end
      assign hit[g] = req_in[g] & ~prev_q;
    end else begin : g_level
      assign hit[g] = req_in[g];
    end
  end

  always_comb begin
    stat_d = (stat_q & ~ack_bits) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/ivc_enable.sv
module ivc_enable #(
  parameter int unsigned NUM_IN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_load,
  input  logic              do_set,
  input  logic              do_clr,
  input  logic [NUM_IN-1:0] data,
  output logic [NUM_IN-1:0] en_q
);
  logic [NUM_IN-1:0] en_d;
  logic              en_ce;

  always_comb begin
    en_ce = do_load | do_set | do_clr;
    en_d  = en_q;
    if (do_load)     en_d = data;
    else if (do_set) en_d = en_q | data;
    else if (do_clr) en_d = en_q & ~data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end
endmodule

// File: rtl/ivc_prio.sv
module ivc_prio #(
  parameter int unsigned NUM_IN = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic [NUM_IN-1:0] req,
  output logic              found,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_IN - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ivc_top.sv
module ivc_top
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_IN    = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_IN-1:0] irq_in,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [1:0]        rst_sync_q;
  logic              rst_sync;
  logic              wr_ack, wr_load, wr_set, wr_clr, wr_mstr;
  logic [NUM_IN-1:0] wdata_n;
  logic [NUM_IN-1:0] ack_bits;
  logic [NUM_IN-1:0] stat_q;
  logic [NUM_IN-1:0] en_q;
  logic [NUM_IN-1:0] pend;
  logic              vec_found;
  logic [IDX_W-1:0]  vec_idx;
  logic [1:0]        mstr_q, mstr_d;
  logic              mstr_ce;
  logic [31:0]       stat_w, en_w, pend_w, vec_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync = rst_sync_q[1];

  always_comb begin
    wr_ack  = reg_we && (reg_addr == SEL_ACK);
    wr_load = reg_we && (reg_addr == SEL_EN);
    wr_set  = reg_we && (reg_addr == SEL_ENSET);
    wr_clr  = reg_we && (reg_addr == SEL_ENCLR);
    wr_mstr = reg_we && (reg_addr == SEL_MSTR);
    wdata_n  = reg_wdata[NUM_IN-1:0];
    ack_bits = wr_ack ? wdata_n : '0;
  end

  ivc_capture #(.NUM_IN(NUM_IN), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk      (clk),
    .rst_n    (rst_sync),
    .req_in   (irq_in),
    .ack_bits (ack_bits),
    .stat_q   (stat_q)
  );

  ivc_enable #(.NUM_IN(NUM_IN)) u_enable (
    .clk     (clk),
    .rst_n   (rst_sync),
    .do_load (wr_load),
    .do_set  (wr_set),
    .do_clr  (wr_clr),
    .data    (wdata_n),
    .en_q    (en_q)
  );

  assign pend = stat_q & en_q;

  ivc_prio #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_prio (
    .req   (pend),
    .found (vec_found),
    .idx   (vec_idx)
  );

  always_comb begin
    mstr_ce = wr_mstr;
    mstr_d  = reg_wdata[1:0];
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync)    mstr_q <= 2'b00;
    else if (mstr_ce) mstr_q <= mstr_d;
  end

  always_comb begin
    stat_w = '0;
    en_w   = '0;
    pend_w = '0;
    stat_w[NUM_IN-1:0] = stat_q;
    en_w[NUM_IN-1:0]   = en_q;
    pend_w[NUM_IN-1:0] = pend;
    vec_w  = '1;
    if (vec_found) begin
      vec_w = '0;
      vec_w[IDX_W-1:0] = vec_idx;
    end
  end

  always_comb begin
    case (reg_addr)
      SEL_STAT: reg_rdata = stat_w;
      SEL_PEND: reg_rdata = pend_w;
      SEL_EN:   reg_rdata = en_w;
      SEL_VEC:  reg_rdata = vec_w;
      SEL_MSTR: reg_rdata = {30'd0, mstr_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_o = (&mstr_q) & (|pend);
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker
  import ivc_pkg::*;
#(
  parameter int unsigned NUM_IN = 32
) (
  input logic              clk,
  input logic              rst_i,
  input logic [2:0]        reg_addr,
  input logic              reg_we,
  input logic [31:0]       reg_wdata,
  input logic              irq_o,
  input logic [NUM_IN-1:0] stat_q,
  input logic [NUM_IN-1:0] en_q,
  input logic [1:0]        mstr_q
);
  logic [NUM_IN-1:0] wd_n;
  logic [NUM_IN-1:0] ack_seen;
  assign wd_n     = reg_wdata[NUM_IN-1:0];
  assign ack_seen = (reg_we && reg_addr == SEL_ACK) ? wd_n : '0;

  // R5
  en_load_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_we && reg_addr == SEL_EN) |=> (en_q == $past(wd_n)));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!reg_we) |=> $stable(en_q));

  // R6
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_we && reg_addr == SEL_ENSET) |=> (en_q == ($past(en_q) | $past(wd_n))));

  // R7
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_we && reg_addr == SEL_ENCLR) |=> (en_q == ($past(en_q) & ~$past(wd_n))));

  // R4
  stat_drop_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (($past(stat_q) & ~$past(ack_seen) & ~stat_q) == '0));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_i)
    irq_o |-> (mstr_q == 2'b11));

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_i)
    irq_o |-> ((stat_q & en_q) != '0));
endmodule

bind ivc_top ivc_checker #(.NUM_IN(NUM_IN)) u_ivc_chk (
  .clk       (clk),
  .rst_i     (rst_sync),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .irq_o     (irq_o),
  .stat_q    (stat_q),
  .en_q      (en_q),
  .mstr_q    (mstr_q)
);

// File: tb/test_ivc_top.sv
module test_ivc_top;
  localparam int          NI = 20;
  localparam logic [31:0] EM = 32'h000F_00F5;
  localparam logic [31:0] VM = 32'h000F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    addr;
  logic          we;
  logic [31:0]   wd;
  logic [NI-1:0] irqs;
  logic [31:0]   rd;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  int rcnt  = 0;
  bit done  = 0;
  logic [NI-1:0] cur_in;

  logic [31:0] m_stat, m_en, m_prev;
  logic [1:0]  m_mst;

  always #5 clk = ~clk;

  ivc_top #(.NUM_IN(NI), .EDGE_MASK(EM)) i_ivc_top (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wd), .reg_rdata(rd), .irq_in(irqs), .irq_o(irq)
  );

  task automatic model_clear();
    m_stat = 0; m_en = 0; m_prev = 0; m_mst = 0;
  endtask

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    logic [31:0] ack, hit, inw, wdm;
    if (!rst_n) begin
      model_clear(); rcnt = 0;
    end else if (rcnt < 2) begin
      model_clear(); rcnt++;
    end else begin
      inw = 0; inw[NI-1:0] = irqs;
      wdm = wd & VM;
      ack = (we && addr == 3) ? wdm : 0;
      hit = 0;
      for (int i = 0; i < NI; i++)
        hit[i] = EM[i] ? (inw[i] & ~m_prev[i]) : inw[i];
      m_stat = (m_stat & ~ack) | hit;
      m_prev = inw;
      if (we) begin
        case (addr)
          3'd2: m_en = wdm;
          3'd4: m_en = m_en | wdm;
          3'd5: m_en = m_en & ~wdm;
          3'd7: m_mst = wd[1:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    logic [31:0] p;
    p = m_stat & m_en;
    case (a)
      3'd0: return m_stat;
      3'd1: return p;
      3'd2: return m_en;
      3'd6: begin
        for (int i = 0; i < NI; i++) if (p[i]) return i;
        return 32'hFFFF_FFFF;
      end
      3'd7: return {30'd0, m_mst};
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    if (rcnt < 2) return "R13";
    case (a)
      3'd0: return "R2 R3 R4 R13";
      3'd1: return "R8 R12";
      3'd2: return "R5 R6 R7 R12";
      3'd6: return "R9";
      3'd7: return "R10";
      default: return "R1";
    endcase
  endfunction

  // compare at the falling edge, away from the active edge
  always @(negedge clk) begin
    logic [31:0] e;
    logic        ei;
    if (!done) begin
      e  = exp_read(addr);
      ei = (m_mst == 2'b11) && ((m_stat & m_en) != 0);
      n_cmp++;
      if (rd !== e) begin
        n_bad++;
        $display("FAIL %s: addr %0d read %h expected %h at %0t", tag_of(addr), addr, rd, e, $time);
      end
      n_cmp++;
      if (irq !== ei) begin
        n_bad++;
        $display("FAIL R11: irq_o %b expected %b at %0t", irq, ei, $time);
      end
    end
  end

  task automatic step(input logic [2:0] a, input logic w, input logic [31:0] d);
    @(posedge clk); #2;
    addr = a; we = w; wd = d; irqs = cur_in;
  endtask

  task automatic rd_at(input logic [2:0] a);
    step(a, 1'b0, 32'h0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; addr = 0; we = 0; wd = 0; cur_in = '0; irqs = '0;
    // R13 reset state on every index
    for (int a = 0; a < 8; a++) rd_at(3'(a));
    @(posedge clk); #2; rst_n = 1'b1;
    repeat (3) rd_at(3'd0);

    // R10 master control, R5 and R12 enable load
    step(3'd7, 1, 32'hFFFF_FFFF); rd_at(3'd7);
    step(3'd2, 1, 32'hFFFF_FFFF); rd_at(3'd2); rd_at(3'd1);

    // R2 edge line 0: pulse, stays latched, then acknowledged
    cur_in = 20'h00001; rd_at(3'd0);
    cur_in = 20'h00000; rd_at(3'd0); rd_at(3'd6);
    step(3'd3, 1, 32'h1); rd_at(3'd0); rd_at(3'd6);

    // R3 and R4 level line 1: acknowledge while high, then after release
    cur_in = 20'h00002; rd_at(3'd0);
    step(3'd3, 1, 32'h2); rd_at(3'd0);
    cur_in = 20'h00000; step(3'd3, 1, 32'h2); rd_at(3'd0);

    // R9 lowest pending index, R7 clear-enable moves the vector
    cur_in = 20'h00220; rd_at(3'd6); cur_in = 20'h00200; rd_at(3'd6);
    step(3'd5, 1, 32'h20); rd_at(3'd6); rd_at(3'd1);
    step(3'd5, 1, 32'hFFFF_FFFF); rd_at(3'd6); rd_at(3'd2);

    // R6 set-enable, R13 writes to read-only indices ignored
    step(3'd4, 1, 32'h200); rd_at(3'd2); rd_at(3'd6);
    step(3'd0, 1, 32'hFFFF_FFFF); rd_at(3'd0);
    step(3'd1, 1, 32'hFFFF_FFFF); rd_at(3'd1);
    step(3'd6, 1, 32'h0); rd_at(3'd6);
    // R1 write-only indices read zero
    rd_at(3'd3); rd_at(3'd4); rd_at(3'd5);

    // R11 output gated by master bits
    step(3'd7, 1, 32'h1); rd_at(3'd7);
    step(3'd7, 1, 32'h2); rd_at(3'd7);
    step(3'd7, 1, 32'h3); rd_at(3'd7);
    cur_in = '0; step(3'd3, 1, 32'hFFFF_FFFF); rd_at(3'd0);

    // mixed traffic
    for (int k = 0; k < 5000; k++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 0) cur_in = cur_in ^ NI'($urandom & $urandom);
      if (r[9:4] == 0) step(3'd3, 1, 32'hFFFF_FFFF);
      else step(3'(r[12:10]), r[14:13] == 0, $urandom & $urandom);
    end

    @(posedge clk); #2;
    done = 1;
    summary();
  end
endmodule